// File: doc/BRIEF.md
# Fast Call/Return Link Unit

This unit performs lightweight subroutine calls and returns. It keeps only the return address on a word stack in data memory and does not save a full register context. It owns the stack-pointer register and the return-address register. It drives one word-wide memory port, which it uses for a single push per call and a single pop per return. It also produces the next program counter and a one-cycle branch pulse.

A call carries the address of the instruction after the call and a target selector. The target is an absolute address, a PC-relative halfword offset, or an address register whose low bit is cleared. On a call, the unit lowers the stack pointer by one word and writes the old return address at the new top. It then loads the return address with the sequential PC and redirects to the target. On a return, the unit branches to the held return address with bit 0 cleared. It reloads the return address from the stack top and raises the stack pointer by one word. Reads wait on a ready handshake. A return requested while a push is in flight is kept and started after the push completes, so stack order is preserved.

Top module: `fcall_link_unit`

## Requirements
- R1: After reset the stack pointer equals the parameter `SP_RESET` (default 0x400). The return address and the PC output are zero, and neither a branch pulse nor a memory request is present.
- R2: A call accepted while idle lowers the stack pointer by 4. In the next cycle, and only in that cycle, it issues a write (`memReq`=1, `memWe`=1) of the previous return-address value at the lowered stack pointer.
- R3: In the cycle after a call is accepted, `branchTaken` is high for exactly one cycle, `pcOut` holds the call target, and `raOut` holds `callNextPc`.
- R4: The target selector `callMode` works as follows. Mode 0 and mode 3 use `callTarget` as is. Mode 1 uses `callPc` plus the sign-extended `callOffset` times 2. Mode 2 uses `callTarget` with bit 0 forced to 0.
- R5: A return accepted while idle issues a read (`memReq`=1, `memWe`=0) at the current stack pointer. The read is held with a stable address until `memReady` is high. In the cycle after that, `branchTaken` pulses and `pcOut` equals the prior return address with bit 0 cleared.
- R6: On return completion, `raOut` becomes the word on `memRdata` sampled with `memReady`, and the stack pointer rises by 4.
- R7: A return requested in the same cycle as an accepted call, or during its write cycle, is kept. It starts in the cycle after the write. A return pending from a write cycle takes priority over a call request in that idle cycle; that call request is ignored.
- R8: Call and return requests made while a read is outstanding have no effect on the stack pointer, the return address or the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Call request, one cycle |
| callMode | input | 2 | Target selector (0 abs, 1 relative, 2 indirect, 3 abs) |
| callPc | input | 32 | PC of the calling instruction |
| callOffset | input | 24 | Signed halfword offset for relative calls |
| callTarget | input | 32 | Absolute or register-held target |
| callNextPc | input | 32 | Address of the instruction after the call |
| retReq | input | 1 | Return request, one cycle |
| memReq | output | 1 | Memory access valid |
| memWe | output | 1 | 1 = write (push), 0 = read (pop) |
| memAddr | output | 32 | Byte address of the stack word |
| memWdata | output | 32 | Word to push |
| memRdata | input | 32 | Word read from the stack |
| memReady | input | 1 | Read data valid this cycle |
| pcOut | output | 32 | Redirected PC |
| branchTaken | output | 1 | One-cycle redirect pulse |
| spOut | output | 32 | Stack-pointer register |
| raOut | output | 32 | Return-address register |

## Verification
A corrupted stack pointer appears on `memAddr` at the next push or pop, and on `spOut` in the same cycle. A wrong saved return address does not show when it is pushed. It shows only when the matching return pops it into `raOut`, and as `pcOut` one return later. Deep call chains with odd return addresses, relative offsets of both signs, and reads stalled by `memReady` are therefore compared each cycle against a behavioural stack model. Lost or reordered pending returns show up as a mismatch on `memReq`/`memWe` within two cycles.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  typedef enum logic [1:0] {
    TGT_ABS = 2'd0,
    TGT_REL = 2'd1,
    TGT_IND = 2'd2,
    TGT_ALT = 2'd3
  } tgtMode_e;

  typedef struct packed {
    logic startCall;
    logic finishRet;
  } fclStrobe_t;
endpackage

// File: rtl/fcl_target.sv
module fcl_target #(
  parameter int XLEN = 32,
  parameter int OFFW = 24
) (
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] curPc,
  input  logic [OFFW-1:0] offset,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] dest
);
  import fcl_pkg::*;
  localparam int EXTW = XLEN - OFFW;

  logic [XLEN-1:0] offExt;
  logic [XLEN-1:0] relDest;

  assign offExt  = {{EXTW{offset[OFFW-1]}}, offset};
  assign relDest = curPc + (offExt << 1);

  always_comb begin
    case (tgtMode_e'(mode))
      TGT_REL: dest = relDest;
      TGT_IND: dest = {target[XLEN-1:1], 1'b0};
      default: dest = target;
    endcase
  end
endmodule

// File: rtl/fcl_ctrl.sv
module fcl_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 callReq,
  input  logic                 retReq,
  input  logic                 memReady,
  output fcl_pkg::fclStrobe_t  strobe,
  output logic                 memReq,
  output logic                 memWe
);
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} ctlState_e;

  ctlState_e state;
  logic      retPending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      retPending <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (retPending) begin
            state      <= ST_POP;
            retPending <= 1'b0;
          end else if (callReq) begin
            state      <= ST_PUSH;
            retPending <= retReq;
          end else if (retReq) begin
            state <= ST_POP;
          end
        end
        ST_PUSH: begin
          state <= ST_IDLE;
          if (retReq) retPending <= 1'b1;
        end
        ST_POP: begin
          if (memReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.startCall = (state == ST_IDLE) && !retPending && callReq;
    strobe.finishRet = (state == ST_POP) && memReady;
    memReq           = (state != ST_IDLE);
    memWe            = (state == ST_PUSH);
  end
endmodule

// File: rtl/fcl_datapath.sv
module fcl_datapath #(
  parameter int              XLEN     = 32,
  parameter int              OFFW     = 24,
  parameter logic [XLEN-1:0] SP_RESET = 'h400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fcl_pkg::fclStrobe_t strobe,
  input  logic [1:0]          callMode,
  input  logic [XLEN-1:0]     callPc,
  input  logic [OFFW-1:0]     callOffset,
  input  logic [XLEN-1:0]     callTarget,
  input  logic [XLEN-1:0]     callNextPc,
  input  logic [XLEN-1:0]     memRdata,
  output logic [XLEN-1:0]     memAddr,
  output logic [XLEN-1:0]     memWdata,
  output logic [XLEN-1:0]     pcOut,
  output logic                branchTaken,
  output logic [XLEN-1:0]     spOut,
  output logic [XLEN-1:0]     raOut
);
  localparam int              WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_BYTES);

  logic [XLEN-1:0] spReg, raReg, pushData, pcReg, callDest;
  logic            brReg;

  fcl_target #(.XLEN(XLEN), .OFFW(OFFW)) tgt_i (
    .mode   (callMode),
    .curPc  (callPc),
    .offset (callOffset),
    .target (callTarget),
    .dest   (callDest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spReg    <= SP_RESET;
      raReg    <= '0;
      pushData <= '0;
      pcReg    <= '0;
      brReg    <= 1'b0;
    end else begin
      brReg <= 1'b0;
      if (strobe.startCall) begin
        pushData <= raReg;
        spReg    <= spReg - STEP;
        raReg    <= callNextPc;
        pcReg    <= callDest;
        brReg    <= 1'b1;
      end else if (strobe.finishRet) begin
        pcReg <= {raReg[XLEN-1:1], 1'b0};
        raReg <= memRdata;
        spReg <= spReg + STEP;
        brReg <= 1'b1;
      end
    end
  end

  assign memAddr     = spReg;
  assign memWdata    = pushData;
  assign pcOut       = pcReg;
  assign branchTaken = brReg;
  assign spOut       = spReg;
  assign raOut       = raReg;
endmodule

// File: rtl/fcall_link_unit.sv
module fcall_link_unit #(
  parameter int              XLEN     = 32,
  parameter int              OFFW     = 24,
  parameter logic [XLEN-1:0] SP_RESET = 'h400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            callReq,
  input  logic [1:0]      callMode,
  input  logic [XLEN-1:0] callPc,
  input  logic [OFFW-1:0] callOffset,
  input  logic [XLEN-1:0] callTarget,
  input  logic [XLEN-1:0] callNextPc,
  input  logic            retReq,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  input  logic            memReady,
  output logic [XLEN-1:0] pcOut,
  output logic            branchTaken,
  output logic [XLEN-1:0] spOut,
  output logic [XLEN-1:0] raOut
);
  fcl_pkg::fclStrobe_t strobe;

  fcl_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .callReq  (callReq),
    .retReq   (retReq),
    .memReady (memReady),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  fcl_datapath #(.XLEN(XLEN), .OFFW(OFFW), .SP_RESET(SP_RESET)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .callMode    (callMode),
    .callPc      (callPc),
    .callOffset  (callOffset),
    .callTarget  (callTarget),
    .callNextPc  (callNextPc),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .pcOut       (pcOut),
    .branchTaken (branchTaken),
    .spOut       (spOut),
    .raOut       (raOut)
  );
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            callReq,
  input logic            retReq,
  input logic [XLEN-1:0] callNextPc,
  input logic            memReq,
  input logic            memWe,
  input logic [XLEN-1:0] memAddr,
  input logic            memReady,
  input logic [XLEN-1:0] pcOut,
  input logic            branchTaken,
  input logic [XLEN-1:0] spOut,
  input logic [XLEN-1:0] raOut
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |=> !(memReq && memWe));

  a_r2_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> (spOut == $past(spOut) - STEP) && (memAddr == spOut));

  a_r3_ra_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> (raOut == $past(callNextPc)) && branchTaken);

  a_r5_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memWe && !memReady) |=> (memReq && !memWe && $stable(memAddr) && !branchTaken));

  a_r6_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memWe && memReady) |=> (spOut == $past(spOut) + STEP) && branchTaken);

  a_r5_ret_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    (branchTaken && !memReq) |-> !pcOut[0]);

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memWe && !memReady) |=> ($stable(spOut) && $stable(raOut)));
endmodule

bind fcall_link_unit fcl_checker #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .callReq     (callReq),
  .retReq      (retReq),
  .callNextPc  (callNextPc),
  .memReq      (memReq),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .memReady    (memReady),
  .pcOut       (pcOut),
  .branchTaken (branchTaken),
  .spOut       (spOut),
  .raOut       (raOut)
);

// File: tb/fcall_link_unit_tb_top.sv
`timescale 1ns/1ps
module fcall_link_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        callReq = 1'b0;
  logic [1:0]  callMode = 2'd0;
  logic [31:0] callPc = '0;
  logic [23:0] callOffset = '0;
  logic [31:0] callTarget = '0;
  logic [31:0] callNextPc = '0;
  logic        retReq = 1'b0;
  logic        memReq, memWe, branchTaken;
  logic [31:0] memAddr, memWdata, memRdata, pcOut, spOut, raOut;
  logic        memReady = 1'b1;
  int          readyCtl = 0;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  fcall_link_unit dut_i (
    .clk(clk), .rst_n(rst_n), .callReq(callReq), .callMode(callMode),
    .callPc(callPc), .callOffset(callOffset), .callTarget(callTarget),
    .callNextPc(callNextPc), .retReq(retReq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .pcOut(pcOut), .branchTaken(branchTaken),
    .spOut(spOut), .raOut(raOut)
  );

  // Stack memory seen through the port
  logic [31:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 32'hA5000000 + 32'(i * 7);
  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) if (rst_n && memReq && memWe) mem[memAddr[9:2]] <= memWdata;

  always @(negedge clk) begin
    if (readyCtl == 0)      memReady = 1'b1;
    else if (readyCtl == 1) memReady = 1'b0;
    else                    memReady = ($urandom % 3) == 0;
  end

  // Behavioural reference model
  int          mPhase = 0;   // 0 idle, 1 writing, 2 reading
  bit          mPend = 0;
  logic [31:0] mSp = 32'h400, mRa = 0, mPc = 0, mPush = 0;
  bit          mBr = 0;

  function automatic logic [31:0] calcTarget(logic [1:0] md, logic [31:0] p,
                                             logic [23:0] o, logic [31:0] t);
    int signed so;
    so = int'($signed(o));
    if (md == 2'd1) return p + 32'(so * 2);
    if (md == 2'd2) return t & 32'hFFFF_FFFE;
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase = 0; mPend = 0; mSp = 32'h400; mRa = 0; mPc = 0; mPush = 0; mBr = 0;
    end else begin
      mBr = 0;
      if (mPhase == 0) begin
        if (mPend) begin
          mPend = 0; mPhase = 2;
        end else if (callReq) begin
          mPush = mRa; mSp = mSp - 4; mRa = callNextPc;
          mPc = calcTarget(callMode, callPc, callOffset, callTarget);
          mBr = 1; mPhase = 1; mPend = retReq;
        end else if (retReq) begin
          mPhase = 2;
        end
      end else if (mPhase == 1) begin
        if (retReq) mPend = 1;
        mPhase = 0;
      end else begin
        if (memReady) begin
          mPc = mRa & 32'hFFFF_FFFE; mRa = memRdata; mSp = mSp + 4;
          mBr = 1; mPhase = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 R5 pcOut", pcOut, mPc);
      chk("R3 R5 branchTaken", 32'(branchTaken), 32'(mBr));
      chk("R2 R6 spOut", spOut, mSp);
      chk("R3 R6 raOut", raOut, mRa);
      chk("R2 R5 R7 R8 memReq", 32'(memReq), 32'(mPhase != 0));
      chk("R2 R5 memWe", 32'(memWe), 32'(mPhase == 1));
      chk("R2 R5 memAddr", memAddr, mSp);
      if (mPhase == 1) chk("R2 memWdata", memWdata, mPush);
    end
  end

  task automatic waitBranch(string tag);
    int n = 0;
    @(negedge clk);
    while (!branchTaken && n < 100) begin @(negedge clk); n++; end
    if (n >= 100) chk({tag, " branch timeout"}, 0, 1);
  endtask

  task automatic issueCall(logic [1:0] md, logic [31:0] p, logic [23:0] o,
                           logic [31:0] t, logic [31:0] nx, bit withRet);
    callReq = 1; callMode = md; callPc = p; callOffset = o; callTarget = t;
    callNextPc = nx; retReq = withRet;
    @(negedge clk);
    callReq = 0; retReq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", spOut, 32'h400);
    chk("R1 ra", raOut, 0);
    chk("R1 pc", pcOut, 0);
    chk("R1 idle", {30'd0, branchTaken, memReq}, 0);

    // R2 R3 absolute call
    issueCall(2'd0, 32'h100, 0, 32'h1000, 32'h204, 0);
    chk("R3 pc abs", pcOut, 32'h1000);
    chk("R3 ra", raOut, 32'h204);
    chk("R2 sp", spOut, 32'h3FC);
    chk("R2 write", {memReq, memWe} , 2'b11);
    chk("R2 data", memWdata, 0);
    @(negedge clk);
    chk("R3 pulse single", 32'(branchTaken), 0);
    chk("R2 write single", 32'(memReq), 0);

    // R4 relative with negative offset
    issueCall(2'd1, 32'h1000, 24'hFFFFF8, 32'hDEAD, 32'h1004, 0);
    chk("R4 relative", pcOut, 32'h0FF0);
    @(negedge clk);
    // R4 indirect clears bit 0, odd next PC
    issueCall(2'd2, 32'h0, 0, 32'h2001, 32'h0FF5, 0);
    chk("R4 indirect", pcOut, 32'h2000);
    @(negedge clk);
    // R4 mode 3 absolute
    issueCall(2'd3, 32'h0, 24'h10, 32'h5003, 32'h0FF5, 0);
    chk("R4 mode3", pcOut, 32'h5003);
    @(negedge clk);
    // pop the mode-3 frame
    retReq = 1; @(negedge clk); retReq = 0;
    waitBranch("R5");
    @(negedge clk);

    // R5 R6 return with stalled ready
    readyCtl = 1;
    retReq = 1; @(negedge clk); retReq = 0;
    repeat (3) @(negedge clk);
    chk("R5 read held", {memReq, memWe}, 2'b10);
    chk("R5 no branch yet", 32'(branchTaken), 0);
    readyCtl = 0;
    waitBranch("R5");
    chk("R5 pc masked", pcOut, 32'h0FF4);
    chk("R6 ra popped", raOut, 32'h1004);
    chk("R6 sp up", spOut, 32'h3F8);
    @(negedge clk);

    // R7 return together with call
    issueCall(2'd0, 0, 0, 32'h3000, 32'h3004, 1);
    chk("R7 call first", pcOut, 32'h3000);
    waitBranch("R7");
    chk("R7 pending ret pc", pcOut, 32'h3004);
    chk("R7 pending ret ra", raOut, 32'h1004);
    chk("R7 pending ret sp", spOut, 32'h3F8);
    @(negedge clk);

    // R8 requests during an outstanding read are ignored
    readyCtl = 1;
    retReq = 1; @(negedge clk); retReq = 0;
    @(negedge clk);
    issueCall(2'd0, 0, 0, 32'h7000, 32'h7004, 0);
    retReq = 1; @(negedge clk); retReq = 0;
    chk("R8 sp unchanged", spOut, 32'h3F8);
    chk("R8 ra unchanged", raOut, 32'h1004);
    readyCtl = 0;
    waitBranch("R8");
    chk("R8 pc", pcOut, 32'h1004);
    chk("R8 sp", spOut, 32'h3FC);
    repeat (2) @(negedge clk);
    chk("R8 no late access", 32'(memReq), 0);

    // Random traffic compared every cycle
    readyCtl = 2;
    for (int i = 0; i < 4000; i++) begin
      callReq    = ($urandom % 4) == 0;
      retReq     = ($urandom % 4) == 0;
      callMode   = 2'($urandom);
      callPc     = $urandom;
      callOffset = 24'($urandom);
      callTarget = $urandom;
      callNextPc = $urandom;
      @(negedge clk);
    end
    callReq = 0; retReq = 0; readyCtl = 0;
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule